// File: doc/BRIEF.md
# Mailbox Ring Poster

This block runs one circular mailbox that lives in host memory. The device uses it to hand fixed-size indication records to the host. Each indication requests one memory write at the current write pointer. The address is the pointer's low bits, with a fixed upper field from a programmed register placed above them. The block then moves the pointer on by one slot. When the advanced pointer would land on the programmed bottom address, it loads the programmed start address instead.

The host owns the read pointer. After it consumes a record, it writes the address of the following slot into that pointer. If the device's pointer becomes equal to the host's pointer after a post, the ring is full and posting stops. Any further indication then waits as pending. It is released when the host moves its read pointer away. Two sticky status bits ("posted" and "full") feed a single interrupt line through per-bit enables. The ring geometry registers are locked while an indication is in progress.

Top module: `mbox_ring`

## Requirements
- R1: After reset, the write pointer is 0, both status bits are 0, `irq` is 0, `mem_valid` is 0 and `ind_ready` is 1.
- R2: A pulse on `ind_valid` while `ind_ready` is high makes the indication pending. While pending, enabled and not full, `mem_valid` is high and `mem_addr` equals {upper start field, write pointer}. `mem_valid` stays high until `mem_ready` is seen, then drops.
- R3: The write pointer moves only in a cycle where `mem_valid` and `mem_ready` are both high, and it moves forward by SLOT_BYTES.
- R4: If the pointer plus SLOT_BYTES equals the bottom address, the pointer loads the lower start address instead.
- R5: Every accepted write sets the posted status bit (bit 0).
- R6: If the new write pointer after an accepted write equals the read pointer, the full flag and the full status bit (bit 1) are set. No write is offered while the full flag is set. Before any post, equal pointers mean empty.
- R7: A host write of a read pointer value that differs from the write pointer clears the full flag, so a pending indication is offered in the next cycle.
- R8: Writes to the upper start (addr 0), lower start (1), bottom (2) and write pointer (3) registers take effect only while `enable` is low or nothing is pending. Otherwise they are ignored. A write-pointer write also clears the full flag.
- R9: Writing the status register (addr 5) clears each status bit whose data bit is 1. A status bit set by hardware in the same cycle stays set.
- R10: `irq` is high exactly when some status bit is set and its enable bit in register addr 6 is set (bit 0 posted, bit 1 full). The enables reset to 0.
- R11: While `enable` is low, no write is offered. `ind_ready` is low while an indication is pending. The read pointer (addr 4) is writable at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows writes to be offered to memory |
| ind_valid | input | 1 | New indication request |
| ind_ready | output | 1 | No indication pending |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | AW_HI+AW_LO | Write address |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register select |
| reg_wdata | input | max(AW_HI,AW_LO) | Host register data |
| wr_ptr | output | AW_LO | Current device write pointer |
| stat_posted | output | 1 | Posted status bit |
| stat_full | output | 1 | Full status bit |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes that `enable` is not lowered while a write is being offered and stalled. It also assumes that the upper start field is not changed while a request is pending. Both follow from the lock rule when the host behaves. The stimulus therefore toggles `enable` only when no write is offered. It changes geometry only while disabled or idle, and otherwise only tries locked writes to show that they are dropped. Start, bottom and pointer values are kept slot-aligned so that the wrap compare can hit.

// File: rtl/mbox_ring.sv
module mbox_ring #(
  parameter int AW_LO      = 16,
  parameter int AW_HI      = 8,
  parameter int SLOT_BYTES = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   enable,
  input  logic                                   ind_valid,
  output logic                                   ind_ready,
  output logic                                   mem_valid,
  input  logic                                   mem_ready,
  output logic [AW_HI+AW_LO-1:0]                 mem_addr,
  input  logic                                   reg_we,
  input  logic [2:0]                             reg_addr,
  input  logic [(AW_HI>AW_LO?AW_HI:AW_LO)-1:0]   reg_wdata,
  output logic [AW_LO-1:0]                       wr_ptr,
  output logic                                   stat_posted,
  output logic                                   stat_full,
  output logic                                   irq
);
  localparam logic [AW_LO-1:0] STEP = AW_LO'(SLOT_BYTES);
  localparam logic [2:0] A_HI = 3'd0, A_LO = 3'd1, A_BOT = 3'd2, A_WP = 3'd3,
                         A_RP = 3'd4, A_ST = 3'd5, A_EN = 3'd6;

  logic [AW_HI-1:0] start_hi;
  logic [AW_LO-1:0] start_lo, bottom, wp, rp, rp_nxt, wp_inc, wp_next;
  logic pend, full_q;
  logic [1:0] irq_en;
  logic accept, cfg_open, hits_rp, clr_post, clr_full;

  assign accept    = mem_valid & mem_ready;
  assign cfg_open  = ~enable | ~pend;
  assign wp_inc    = wp + STEP;
  assign wp_next   = (wp_inc == bottom) ? start_lo : wp_inc;
  assign rp_nxt    = (reg_we && reg_addr == A_RP) ? reg_wdata[AW_LO-1:0] : rp;
  assign hits_rp   = (wp_next == rp_nxt);
  assign clr_post  = reg_we && reg_addr == A_ST && reg_wdata[0];
  assign clr_full  = reg_we && reg_addr == A_ST && reg_wdata[1];

  assign ind_ready = ~pend;
  assign mem_valid = pend & enable & ~full_q;
  assign mem_addr  = {start_hi, wp};
  assign wr_ptr    = wp;
  assign irq       = (stat_posted & irq_en[0]) | (stat_full & irq_en[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_hi    <= '0;
      start_lo    <= '0;
      bottom      <= '0;
      wp          <= '0;
      rp          <= '0;
      pend        <= 1'b0;
      full_q      <= 1'b0;
      irq_en      <= '0;
      stat_posted <= 1'b0;
      stat_full   <= 1'b0;
    end else begin
      if (accept)                pend <= 1'b0;
      else if (ind_valid)        pend <= 1'b1;

      if (reg_we && cfg_open) begin
        if (reg_addr == A_HI)  start_hi <= reg_wdata[AW_HI-1:0];
        if (reg_addr == A_LO)  start_lo <= reg_wdata[AW_LO-1:0];
        if (reg_addr == A_BOT) bottom   <= reg_wdata[AW_LO-1:0];
      end
      if (reg_we && reg_addr == A_EN) irq_en <= reg_wdata[1:0];
      rp <= rp_nxt;

      if (accept) begin
        wp     <= wp_next;
        full_q <= hits_rp;
      end else if (reg_we && cfg_open && reg_addr == A_WP) begin
        wp     <= reg_wdata[AW_LO-1:0];
        full_q <= 1'b0;
      end else if (reg_we && reg_addr == A_RP && reg_wdata[AW_LO-1:0] != wp) begin
        full_q <= 1'b0;
      end

      stat_posted <= accept | (stat_posted & ~clr_post);
      stat_full   <= (accept & hits_rp) | (stat_full & ~clr_full);
    end
  end
endmodule

// File: rtl/mbox_ring_chk.sv
module mbox_ring_chk #(
  parameter int AW_LO      = 16,
  parameter int AW_HI      = 8,
  parameter int SLOT_BYTES = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   enable,
  input logic                   mem_valid,
  input logic                   mem_ready,
  input logic [AW_HI+AW_LO-1:0] mem_addr,
  input logic [AW_LO-1:0]       wr_ptr,
  input logic [AW_LO-1:0]       start_lo,
  input logic                   full_q,
  input logic                   stat_posted,
  input logic                   stat_full,
  input logic                   irq
);
  localparam logic [AW_LO-1:0] STEP = AW_LO'(SLOT_BYTES);

  assert_hold_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && enable) |=> mem_valid);

  assert_stall_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> ($stable(wr_ptr) && $stable(mem_addr)));

  assert_step_or_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (wr_ptr == $past(wr_ptr + STEP) || wr_ptr == start_lo));

  assert_posted_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> stat_posted);

  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> (stat_full || !$past(mem_valid && mem_ready)) );

  assert_quiet_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_posted && !stat_full) |-> !irq);

  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !mem_valid);
endmodule

bind mbox_ring mbox_ring_chk #(.AW_LO(AW_LO), .AW_HI(AW_HI), .SLOT_BYTES(SLOT_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .wr_ptr(wr_ptr), .start_lo(start_lo), .full_q(full_q),
  .stat_posted(stat_posted), .stat_full(stat_full), .irq(irq));

// File: tb/test_mbox_ring.sv
`timescale 1ns/1ps
module test_mbox_ring;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, ind_valid = 1'b0, mem_ready = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic ind_ready, mem_valid, stat_posted, stat_full, irq;
  logic [23:0] mem_addr;
  logic [15:0] wr_ptr;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  mbox_ring i_mbox_ring (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ind_valid(ind_valid), .ind_ready(ind_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .wr_ptr(wr_ptr), .stat_posted(stat_posted),
    .stat_full(stat_full), .irq(irq));

  // {stall cycles, expected address, pointer after accept, full after accept}
  localparam logic [55:0] VEC [4] = '{
    {8'd0, 24'hAB0100, 16'h0110, 8'd0},
    {8'd2, 24'hAB0110, 16'h0120, 8'd0},
    {8'd1, 24'hAB0120, 16'h0130, 8'd0},
    {8'd0, 24'hAB0130, 16'h0100, 8'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic pulse_ind();
    @(negedge clk); ind_valid = 1'b1;
    @(negedge clk); ind_valid = 1'b0;
  endtask

  task automatic accept_one();
    mem_ready = 1'b1;
    @(negedge clk); mem_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wr_ptr", 32'(wr_ptr), 0);
    chk("R1 status", {30'd0, stat_full, stat_posted}, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_valid", 32'(mem_valid), 0);
    chk("R1 ind_ready", 32'(ind_ready), 1);

    wreg(3'd0, 16'h00AB);
    wreg(3'd1, 16'h0100);
    wreg(3'd2, 16'h0140);
    wreg(3'd3, 16'h0100);
    wreg(3'd4, 16'h0100);
    @(negedge clk); enable = 1'b1;

    prev = 16'h0100;
    for (int i = 0; i < 4; i++) begin
      pulse_ind();
      chk("R2 mem_valid", 32'(mem_valid), 1);
      chk("R2 mem_addr", 32'(mem_addr), 32'(VEC[i][47:24]));
      for (int s = 0; s < int'(VEC[i][55:48]); s++) begin
        @(negedge clk);
        chk("R3 stall pointer", 32'(wr_ptr), 32'(prev));
        chk("R2 held valid", 32'(mem_valid), 1);
      end
      accept_one();
      chk("R3/R4 pointer", 32'(wr_ptr), 32'(VEC[i][23:8]));
      chk("R2 drop", 32'(mem_valid), 0);
      chk("R5 posted", 32'(stat_posted), 1);
      chk("R6 full", 32'(stat_full), 32'(VEC[i][7:0]));
      prev = VEC[i][23:8];
    end

    wreg(3'd5, 16'h0002);
    chk("R9 full cleared", 32'(stat_full), 0);
    chk("R9 posted kept", 32'(stat_posted), 1);

    pulse_ind();
    chk("R6 no offer when full", 32'(mem_valid), 0);
    chk("R11 ready low pending", 32'(ind_ready), 0);
    wreg(3'd3, 16'h0200);
    wreg(3'd0, 16'h0055);
    chk("R8 locked wp ignored", 32'(wr_ptr), 32'h0100);
    chk("R6 still blocked", 32'(mem_valid), 0);
    wreg(3'd4, 16'h0110);
    chk("R7 offer after rp move", 32'(mem_valid), 1);
    chk("R8 locked hi ignored", 32'(mem_addr), 32'hAB0100);
    accept_one();
    chk("R6 refull", 32'(stat_full), 1);
    chk("R3 pointer", 32'(wr_ptr), 32'h0110);

    wreg(3'd4, 16'h0120);
    pulse_ind();
    chk("R7 offer", 32'(mem_valid), 1);
    reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 16'h0001; mem_ready = 1'b1;
    @(negedge clk); reg_we = 1'b0; mem_ready = 1'b0;
    chk("R9 set wins", 32'(stat_posted), 1);
    chk("R6 full at rp", 32'(stat_full), 1);

    chk("R10 masked", 32'(irq), 0);
    wreg(3'd6, 16'h0002);
    chk("R10 full irq", 32'(irq), 1);
    wreg(3'd5, 16'h0002);
    chk("R10 cleared irq", 32'(irq), 0);
    wreg(3'd6, 16'h0001);
    chk("R10 posted irq", 32'(irq), 1);

    @(negedge clk); enable = 1'b0;
    wreg(3'd4, 16'h0130);
    pulse_ind();
    chk("R11 disabled no offer", 32'(mem_valid), 0);
    wreg(3'd3, 16'h0100);
    chk("R8 open wp write", 32'(wr_ptr), 32'h0100);
    @(negedge clk); enable = 1'b1;
    #1;
    chk("R2 offer after enable", 32'(mem_valid), 1);
    chk("R2 addr after enable", 32'(mem_addr), 32'hAB0100);
    @(negedge clk);
    accept_one();
    chk("R3 final pointer", 32'(wr_ptr), 32'h0110);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule